// File: doc/BRIEF.md
# Cache Victim Way Selector (LRU / FIFO)

This block picks which way of a set-associative cache set is evicted when a miss has to displace a line. A mode input selects between two policies. In the least-recently-used policy, each line carries a small saturating age counter. In the first-in-first-out policy, each set carries a round-robin pointer. Tag lookup, valid tracking and the memory side belong to the surrounding cache. This block only keeps the replacement state and answers victim queries.

The cache controller reports every reference to the block. A hit is reported on the access inputs, with the set and way that were touched. A miss that installs a line is reported on the fill inputs, with a flag that marks whether an occupied way was displaced. The controller may ask for the victim of any set at any time. The answer is combinational from the query set index. State changes from an event appear on the clock edge that samples it.

Top module: `cache_victim_sel`

## Requirements
- R1: After reset every line is unfilled and every set pointer is 0, so the victim of every set is way 0 in both modes.
- R2: In LRU mode (`lru_mode`=1), each access or fill event adds one to the age of every filled line in every set, except the touched line.
- R3: A line that has never been accessed or filled is not aged. It ranks below every filled line, so it is never chosen while its set holds a filled line.
- R4: In LRU mode, the line named by an access, or by a fill of either kind, becomes filled and gets age 0.
- R5: In LRU mode, the victim is the filled way with the largest age. Among equal ages the lowest way index wins. A set with no filled line yields way 0.
- R6: Ages saturate at 2^AGE_W-1 and do not wrap.
- R7: In FIFO mode (`lru_mode`=0), the victim is the set's pointer. A fill with `fill_replace`=1 moves that set's pointer forward by one, wrapping from NUM_WAYS-1 to 0.
- R8: In FIFO mode, a fill with `fill_replace`=0, or an access, leaves every pointer unchanged.
- R9: `victim_way` follows `qry_set` and `lru_mode` with no clock edge. State changes caused by an event show only after the rising edge that samples it.
- R10: Ages and fill marks are frozen while in FIFO mode. Pointers are frozen while in LRU mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| lru_mode | input | 1 | 1 selects LRU, 0 selects FIFO |
| acc_valid | input | 1 | Hit reported this cycle (never together with fill_valid) |
| acc_set | input | SET_W | Set of the hit |
| acc_way | input | WAY_W | Way of the hit |
| fill_valid | input | 1 | Line installed this cycle |
| fill_set | input | SET_W | Set of the fill |
| fill_way | input | WAY_W | Way written by the fill |
| fill_replace | input | 1 | 1 when the fill displaced an occupied way |
| qry_set | input | SET_W | Set whose victim is requested |
| victim_way | output | WAY_W | Chosen victim way for qry_set |

## Verification
The bench builds the block with 4 sets, 4 ways and 3-bit ages. With only 3 age bits, a line reaches saturation after seven events, and a wrapping counter would change the winner in a short directed sequence. With four ways, a few replacements carry the FIFO pointer through its wrap. A reference model in the bench checks the victim of every set after every event, across a long mixed sequence that includes mode changes.

// File: rtl/cvs_pkg.sv
// Shared definitions for the cache victim selector.
// Assumes nothing beyond standard SystemVerilog packages.
package cvs_pkg;
    typedef enum logic {
        POL_FIFO = 1'b0,
        POL_LRU  = 1'b1
    } policy_e;
endpackage

// File: rtl/cvs_age_array.sv
// Per-line saturating age counters with fill marks, and the LRU victim search.
// Assumes at most one touch event per cycle. Unfilled lines rank below any
// filled line. Ties resolve to the lowest way index.
module cvs_age_array #(
    parameter int SETS  = 4,
    parameter int WAYS  = 4,
    parameter int AGE_W = 3,
    localparam int SET_W = $clog2(SETS),
    localparam int WAY_W = $clog2(WAYS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             tick,
    input  logic [SET_W-1:0] hit_set,
    input  logic [WAY_W-1:0] hit_way,
    input  logic [SET_W-1:0] qry_set,
    output logic [WAY_W-1:0] lru_way
);
    localparam logic [AGE_W-1:0] AGE_MAX = {AGE_W{1'b1}};

    logic [AGE_W-1:0] age_q  [SETS][WAYS];
    logic             used_q [SETS][WAYS];
    logic [AGE_W:0]   qscore [WAYS];

    // Age every filled line and clear the touched one on each event.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < SETS; s++)
                for (int w = 0; w < WAYS; w++) begin
                    age_q[s][w]  <= '0;
                    used_q[s][w] <= 1'b0;
                end
        end else if (en && tick) begin
            for (int s = 0; s < SETS; s++)
                for (int w = 0; w < WAYS; w++) begin
                    if (hit_set == SET_W'(s) && hit_way == WAY_W'(w)) begin
                        age_q[s][w]  <= '0;
                        used_q[s][w] <= 1'b1;
                    end else if (used_q[s][w] && age_q[s][w] != AGE_MAX) begin
                        age_q[s][w] <= age_q[s][w] + 1'b1;
                    end
                end
        end
    end

    // Rank the lines of the queried set: the fill mark is above the age.
    always_comb begin
        for (int w = 0; w < WAYS; w++)
            qscore[w] = {used_q[qry_set][w], age_q[qry_set][w]};
    end

    // Pick the highest rank; strict compare keeps the lowest index on ties.
    always_comb begin
        logic [AGE_W:0] best;
        best    = qscore[0];
        lru_way = '0;
        for (int w = 1; w < WAYS; w++) begin
            if (qscore[w] > best) begin
                best    = qscore[w];
                lru_way = WAY_W'(w);
            end
        end
    end

    for (genvar w = 0; w < WAYS; w++) begin : g_rank_chk
        // R5: no other way outranks the chosen one.
        p_victim_max_r5: assert property (@(posedge clk) disable iff (!rst_n)
            qscore[w] <= qscore[lru_way]);
        // R5: a lower way never ties the chosen one.
        p_tie_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
            (WAY_W'(w) < lru_way) |-> (qscore[w] < qscore[lru_way]));
    end

    for (genvar s = 0; s < SETS; s++) begin : g_set_chk
        for (genvar w = 0; w < WAYS; w++) begin : g_line_chk
            // R4: the touched line reads age 0 after the edge.
            p_touch_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
                (en && tick && hit_set == SET_W'(s) && hit_way == WAY_W'(w))
                |=> (age_q[s][w] == '0 && used_q[s][w]));
            // R6: a saturated untouched line stays saturated.
            p_saturate_r6: assert property (@(posedge clk) disable iff (!rst_n)
                (age_q[s][w] == AGE_MAX &&
                 !(tick && hit_set == SET_W'(s) && hit_way == WAY_W'(w)))
                |=> age_q[s][w] == AGE_MAX);
            // R10: ages and marks hold while the policy is FIFO.
            p_frozen_r10: assert property (@(posedge clk) disable iff (!rst_n)
                !en |=> ($stable(age_q[s][w]) && $stable(used_q[s][w])));
            // R3: an unfilled line does not age.
            p_unused_still_r3: assert property (@(posedge clk) disable iff (!rst_n)
                (!used_q[s][w] && !(tick && hit_set == SET_W'(s) && hit_way == WAY_W'(w)))
                |=> $stable(age_q[s][w]));
        end
    end
endmodule

// File: rtl/cvs_fifo_bank.sv
// Per-set round-robin replacement pointers for the FIFO policy.
// Assumes the pointer moves only when an occupied way is displaced.
module cvs_fifo_bank #(
    parameter int SETS = 4,
    parameter int WAYS = 4,
    localparam int SET_W = $clog2(SETS),
    localparam int WAY_W = $clog2(WAYS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             adv,
    input  logic [SET_W-1:0] adv_set,
    input  logic [SET_W-1:0] qry_set,
    output logic [WAY_W-1:0] fifo_way
);
    localparam logic [WAY_W-1:0] LAST_WAY = WAY_W'(WAYS - 1);

    logic [WAY_W-1:0] ptr_q [SETS];

    // Step the pointer of the replaced set, wrapping after the last way.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < SETS; s++) ptr_q[s] <= '0;
        end else if (en && adv) begin
            ptr_q[adv_set] <= (ptr_q[adv_set] == LAST_WAY) ? '0 : ptr_q[adv_set] + 1'b1;
        end
    end

    // Present the queried set's pointer as the victim.
    assign fifo_way = ptr_q[qry_set];

    for (genvar s = 0; s < SETS; s++) begin : g_ptr_chk
        // R7: a replacement moves the pointer by one, wrapping at the end.
        p_adv_wrap_r7: assert property (@(posedge clk) disable iff (!rst_n)
            (en && adv && adv_set == SET_W'(s))
            |=> ptr_q[s] == (($past(ptr_q[s]) == LAST_WAY) ? '0 : $past(ptr_q[s]) + 1'b1));
        // R8: no replacement for this set means no motion.
        p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
            !(en && adv && adv_set == SET_W'(s)) |=> $stable(ptr_q[s]));
    end
endmodule

// File: rtl/cache_victim_sel.sv
// Victim way selector for a set-associative cache, LRU or FIFO by mode.
// Assumes the controller never reports a hit and a fill in the same cycle.
// The victim is combinational from the query set. Updates land on the next edge.
module cache_victim_sel #(
    parameter int NUM_SETS = 4,
    parameter int NUM_WAYS = 4,
    parameter int AGE_W    = 3,
    localparam int SET_W = $clog2(NUM_SETS),
    localparam int WAY_W = $clog2(NUM_WAYS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             lru_mode,
    input  logic             acc_valid,
    input  logic [SET_W-1:0] acc_set,
    input  logic [WAY_W-1:0] acc_way,
    input  logic             fill_valid,
    input  logic [SET_W-1:0] fill_set,
    input  logic [WAY_W-1:0] fill_way,
    input  logic             fill_replace,
    input  logic [SET_W-1:0] qry_set,
    output logic [WAY_W-1:0] victim_way
);
    import cvs_pkg::*;

    policy_e          pol;
    logic             tick;
    logic [SET_W-1:0] touch_set;
    logic [WAY_W-1:0] touch_way;
    logic [WAY_W-1:0] lru_way;
    logic [WAY_W-1:0] fifo_way;

    // Merge the two event sources into one touch.
    always_comb begin
        pol       = policy_e'(lru_mode);
        tick      = acc_valid | fill_valid;
        touch_set = fill_valid ? fill_set : acc_set;
        touch_way = fill_valid ? fill_way : acc_way;
    end

    cvs_age_array #(.SETS(NUM_SETS), .WAYS(NUM_WAYS), .AGE_W(AGE_W)) i_age (
        .clk(clk), .rst_n(rst_n), .en(pol == POL_LRU), .tick(tick),
        .hit_set(touch_set), .hit_way(touch_way), .qry_set(qry_set),
        .lru_way(lru_way)
    );

    cvs_fifo_bank #(.SETS(NUM_SETS), .WAYS(NUM_WAYS)) i_fifo (
        .clk(clk), .rst_n(rst_n), .en(pol == POL_FIFO),
        .adv(fill_valid & fill_replace), .adv_set(fill_set),
        .qry_set(qry_set), .fifo_way(fifo_way)
    );

    // Select the answer of the active policy.
    assign victim_way = (pol == POL_LRU) ? lru_way : fifo_way;

    // Input rule: a hit and a fill never share a cycle.
    p_single_event_in: assert property (@(posedge clk) disable iff (!rst_n)
        !(acc_valid && fill_valid));
    // R1: right after reset every set answers way 0.
    p_reset_zero_r1: assert property (@(posedge clk)
        !rst_n |=> victim_way == '0);
endmodule

// File: tb/test_cache_victim_sel.sv
module test_cache_victim_sel;
    localparam int CLK_PERIOD = 20;
    localparam int SETS = 4;
    localparam int WAYS = 4;
    localparam int AW   = 3;
    localparam int AMAX = (1 << AW) - 1;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       lru_mode = 1'b1;
    logic       acc_valid = 1'b0, fill_valid = 1'b0, fill_replace = 1'b0;
    logic [1:0] acc_set = '0, fill_set = '0, qry_set = '0;
    logic [1:0] acc_way = '0, fill_way = '0;
    logic [1:0] victim_way;

    int checks = 0;
    int failures = 0;
    int cycles = 0;
    int m_age [SETS][WAYS];
    bit m_used [SETS][WAYS];
    int m_ptr [SETS];

    cache_victim_sel #(.NUM_SETS(SETS), .NUM_WAYS(WAYS), .AGE_W(AW)) i_cache_victim_sel (
        .clk(clk), .rst_n(rst_n), .lru_mode(lru_mode),
        .acc_valid(acc_valid), .acc_set(acc_set), .acc_way(acc_way),
        .fill_valid(fill_valid), .fill_set(fill_set), .fill_way(fill_way),
        .fill_replace(fill_replace), .qry_set(qry_set), .victim_way(victim_way)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 100000) begin
                failures++;
                $display("FAIL watchdog: run hung, actual=%0d expected<=100000", cycles);
                $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
                $finish;
            end
        end
    end

    function automatic int exp_victim(int s);
        int best, bw;
        if (!lru_mode) return m_ptr[s];
        best = -2; bw = 0;
        for (int w = 0; w < WAYS; w++) begin
            int sc;
            sc = m_used[s][w] ? m_age[s][w] : -1;
            if (sc > best) begin best = sc; bw = w; end
        end
        return bw;
    endfunction

    task automatic check_one(string tag, int s, int exp);
        qry_set = 2'(s);
        #1;
        checks++;
        if (int'(victim_way) != exp) begin
            failures++;
            $display("FAIL %s set=%0d mode=%0d actual=%0d expected=%0d",
                     tag, s, lru_mode, victim_way, exp);
        end
    endtask

    task automatic check_all(string tag);
        for (int s = 0; s < SETS; s++) check_one(tag, s, exp_victim(s));
    endtask

    // kind: 0 access, 1 fill into empty way, 2 fill with replacement
    task automatic ev(int kind, int s, int w);
        @(negedge clk);
        acc_valid    = (kind == 0);
        fill_valid   = (kind != 0);
        fill_replace = (kind == 2);
        acc_set = 2'(s); acc_way = 2'(w);
        fill_set = 2'(s); fill_way = 2'(w);
        @(posedge clk);
        #1;
        acc_valid = 1'b0; fill_valid = 1'b0; fill_replace = 1'b0;
        if (lru_mode) begin
            for (int a = 0; a < SETS; a++)
                for (int b = 0; b < WAYS; b++) begin
                    if (a == s && b == w) begin m_age[a][b] = 0; m_used[a][b] = 1; end
                    else if (m_used[a][b] && m_age[a][b] < AMAX) m_age[a][b]++;
                end
        end else if (kind == 2) begin
            m_ptr[s] = (m_ptr[s] + 1) % WAYS;
        end
    endtask

    task automatic set_mode(bit m);
        @(negedge clk);
        lru_mode = m;
        #1;
    endtask

    initial begin
        for (int s = 0; s < SETS; s++) begin
            m_ptr[s] = 0;
            for (int w = 0; w < WAYS; w++) begin m_age[s][w] = 0; m_used[s][w] = 0; end
        end
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        #1;

        // R1: reset state in both modes
        check_all("R1");
        set_mode(0); check_all("R1");
        set_mode(1);

        // R3: single filled line in set 2 wins over unfilled ones
        ev(1, 2, 2); check_all("R3");
        check_one("R3", 2, 2);

        // R4: touched line drops to age 0
        ev(1, 0, 0); ev(1, 0, 1); ev(0, 0, 0);
        check_one("R4", 0, 1);

        // R6: saturation keeps a tie that wrapping would break
        ev(1, 1, 0); ev(1, 1, 1);
        for (int i = 0; i < 7; i++) ev(0, 3, 3);
        check_one("R6", 1, 0);
        check_all("R6");

        // R10: FIFO activity leaves ages untouched
        set_mode(0);
        ev(0, 1, 1); ev(1, 1, 2); ev(2, 2, 0);
        set_mode(1); check_all("R10");
        check_one("R10", 1, 0);
        set_mode(0); check_one("R10", 2, 1);

        // R7: five replacements in set 0 wrap the pointer to 1
        for (int i = 0; i < 5; i++) begin ev(2, 0, m_ptr[0]); check_all("R7"); end
        check_one("R7", 0, 1);

        // R8: non-replacing fills and accesses do not move pointers
        ev(1, 3, 0); ev(0, 3, 1); ev(1, 0, 3);
        check_all("R8");
        check_one("R8", 3, 0);

        // R9: before the sampling edge the old victim is still shown
        @(negedge clk);
        fill_valid = 1'b1; fill_replace = 1'b1; fill_set = 2'd3; fill_way = 2'd0;
        check_one("R9", 3, 0);
        @(posedge clk); #1;
        fill_valid = 1'b0; fill_replace = 1'b0;
        m_ptr[3] = 1;
        check_one("R9", 3, 1);
        lru_mode = 1'b1;
        check_one("R9", 3, exp_victim(3));
        lru_mode = 1'b0;

        // R2 R5 R7: long mixed sweep against the model
        for (int i = 0; i < 800; i++) begin
            int k, s, w;
            if (i % 60 == 0) set_mode(((i / 60) % 2) == 0);
            k = int'($urandom_range(0, 2));
            s = int'($urandom_range(0, SETS - 1));
            w = (k == 2) ? exp_victim(s) : int'($urandom_range(0, WAYS - 1));
            ev(k, s, w);
            check_all(lru_mode ? "R2 R5" : "R7 R8");
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule